// File: doc/BRIEF.md
# Two-Voice Pitch Step Sequencer with Tape Sync Start

The block reads a stored note sequence and plays it on two independent voices. For each voice it drives the select codes of three 8-way multiplexers. Each multiplexer taps a ladder of eight equal resistors, and the ladders sit in an external digital-to-analog converter. Two of the selects set the step within the octave, which gives 16 steps per octave. The third select picks the octave.

Playback does not start on a command. It starts when a tone recorded on a tape track ends. The digitised tone level must first stay high for a minimum debounce time. Playback then begins when that level drops back to zero. Every track recorded against the same sync tone therefore starts on the same beat.

The sequence memory is read through a synchronous read port, with data valid one cycle after the address. Each word holds one step: a pitch for each voice and a duration counted in tempo ticks. A built-in prescaler divides the clock down to the tempo tick. A step whose duration is zero ends the sequence.

Top module: `pitch_seq_2v`

## Requirements
- R1: While reset is held and right after it is released, `busy` is 0, `mem_addr` is 0 and all select outputs are 0.
- R2: Playback is armed only after `sync_lvl` has been high for DEB_LEN consecutive cycles. A shorter high pulse followed by a low level does not start playback.
- R3: Once armed, the first cycle in which `sync_lvl` is low starts playback. In that clock edge `busy` goes to 1 and `mem_addr` goes to 0. While playback runs, `sync_lvl` is ignored.
- R4: The step word is laid out as follows: bits [15:0] hold the duration, bits [21:16] hold the voice 0 pitch, and bits [27:22] hold the voice 1 pitch. For a pitch p, the octave select is p[5:4], the coarse select is p[3:2] and the fine select is p[1:0]. Each select is zero-extended to 3 bits. Voice 0 uses bits [2:0] of `oct_sel`, `hi_sel` and `lo_sel`; voice 1 uses bits [5:3].
- R5: A step with duration d > 0 holds its select outputs for exactly d*TICK_DIV+2 cycles. These are d tempo ticks, plus two cycles for the memory fetch.
- R6: A step with duration 0 clears `busy` and returns the block to waiting for a new sync tone. The select outputs keep the values of the last played step.
- R7: The select outputs of both voices change only on the clock edge that loads a step, and they change on the same edge.
- R8: Between steps, `mem_addr` increases by one and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_lvl | input | 1 | Digitised level of the tape sync tone |
| mem_addr | output | ADDR_W | Step address to the sequence memory |
| mem_data | input | 28 | Step word, valid one cycle after the address |
| oct_sel | output | 6 | Octave ladder selects, voice 1 in [5:3], voice 0 in [2:0] |
| hi_sel | output | 6 | Coarse in-octave ladder selects, same packing |
| lo_sel | output | 6 | Fine in-octave ladder selects, same packing |
| busy | output | 1 | High while a sequence is playing |

## Verification
The hardest state to reach from the ports is the address wrap. It needs a sequence that runs past the last memory word with no end marker. The bench fills every word with a short step and lets the address go round. Once the address is back near the start, it writes an end marker ahead of the read pointer. A sync pulse cut short just before the debounce limit, and then raised again, checks that the debounce count restarts.

// File: rtl/pitch_seq_pkg.sv
package pitch_seq_pkg;
   localparam int PITCH_W = 6;
   localparam int DUR_W   = 16;
   localparam int VOICES  = 2;
   localparam int SEL_W   = 3;
   localparam int STEP_W  = VOICES * PITCH_W + DUR_W;

   typedef enum logic [2:0] {
      S_WAIT,
      S_ARM,
      S_REQ,
      S_LOAD,
      S_PLAY
   } seq_state_e;
endpackage

// File: rtl/seq_tone_qual.sv
module seq_tone_qual #(
   parameter int DEB_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sync_lvl,
   output logic seen
);
   localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

   logic [CW-1:0] run_q;
   logic          at_lim;

   assign at_lim = (run_q == CW'(DEB_LEN - 1));
   assign seen   = en & sync_lvl & at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n || !en || !sync_lvl) begin
         run_q <= '0;
      end else if (!at_lim) begin
         run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/seq_voice_map.sv
module seq_voice_map
   import pitch_seq_pkg::*;
(
   input  logic [PITCH_W-1:0] pitch,
   output logic [SEL_W-1:0]   oct,
   output logic [SEL_W-1:0]   hi,
   output logic [SEL_W-1:0]   lo
);
   assign oct = {1'b0, pitch[5:4]};
   assign hi  = {1'b0, pitch[3:2]};
   assign lo  = {1'b0, pitch[1:0]};
endmodule

// File: rtl/pitch_seq_2v.sv
module pitch_seq_2v
   import pitch_seq_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int TICK_DIV = 250,
   parameter int DEB_LEN  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sync_lvl,
   output logic [ADDR_W-1:0]       mem_addr,
   input  logic [27:0]             mem_data,
   output logic [5:0]              oct_sel,
   output logic [5:0]              hi_sel,
   output logic [5:0]              lo_sel,
   output logic                    busy
);
   if (ADDR_W < 1 || TICK_DIV < 1 || DEB_LEN < 1) begin : g_bad_param
      $error("pitch_seq_2v: ADDR_W, TICK_DIV and DEB_LEN must be at least 1");
   end
   if (STEP_W != 28 || VOICES * SEL_W != 6) begin : g_bad_fmt
      $error("pitch_seq_2v: step format does not match the port widths");
   end

   seq_state_e         st;
   logic [DUR_W-1:0]   dcnt_q;
   logic [PITCH_W-1:0] pitch_q [VOICES];
   logic [DUR_W-1:0]   step_dur;
   logic               seen;
   logic               tick;

   assign step_dur = mem_data[DUR_W-1:0];
   assign busy     = (st == S_REQ) || (st == S_LOAD) || (st == S_PLAY);

   seq_tone_qual #(.DEB_LEN(DEB_LEN)) i_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (st == S_WAIT),
      .sync_lvl (sync_lvl),
      .seen     (seen)
   );

   seq_tick_gen #(.DIV(TICK_DIV)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st != S_PLAY),
      .tick  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_WAIT;
         mem_addr <= '0;
         dcnt_q   <= '0;
         for (int v = 0; v < VOICES; v++) pitch_q[v] <= '0;
      end else begin
         unique case (st)
            S_WAIT: if (seen) st <= S_ARM;
            S_ARM: begin
               if (!sync_lvl) begin
                  st       <= S_REQ;
                  mem_addr <= '0;
               end
            end
            S_REQ: st <= S_LOAD;
            S_LOAD: begin
               if (step_dur == '0) begin
                  st <= S_WAIT;
               end else begin
                  st     <= S_PLAY;
                  dcnt_q <= step_dur;
                  for (int v = 0; v < VOICES; v++)
                     pitch_q[v] <= mem_data[DUR_W + v*PITCH_W +: PITCH_W];
               end
            end
            S_PLAY: begin
               if (tick) begin
                  if (dcnt_q == DUR_W'(1)) begin
                     st       <= S_REQ;
                     mem_addr <= mem_addr + 1'b1;
                  end else begin
                     dcnt_q <= dcnt_q - 1'b1;
                  end
               end
            end
            default: st <= S_WAIT;
         endcase
      end
   end

   for (genvar v = 0; v < VOICES; v++) begin : g_voice
      seq_voice_map i_map (
         .pitch (pitch_q[v]),
         .oct   (oct_sel[v*SEL_W +: SEL_W]),
         .hi    (hi_sel[v*SEL_W +: SEL_W]),
         .lo    (lo_sel[v*SEL_W +: SEL_W])
      );
   end
endmodule

// File: rtl/pitch_seq_2v_chk.sv
module pitch_seq_2v_chk
   import pitch_seq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_lvl,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [5:0]        oct_sel,
   input logic [5:0]        hi_sel,
   input logic [5:0]        lo_sel,
   input logic              busy,
   input seq_state_e        st
);
   assert_start_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> mem_addr == '0);

   assert_start_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(st) == S_ARM && !$past(sync_lvl)));

   assert_end_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($stable(oct_sel) && $stable(hi_sel) && $stable(lo_sel)));

   assert_load_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(oct_sel) || !$stable(hi_sel) || !$stable(lo_sel)) |-> $past(st) == S_LOAD);

   assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mem_addr)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
endmodule

bind pitch_seq_2v pitch_seq_2v_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync_lvl (sync_lvl),
   .mem_addr (mem_addr),
   .oct_sel  (oct_sel),
   .hi_sel   (hi_sel),
   .lo_sel   (lo_sel),
   .busy     (busy),
   .st       (st)
);

// File: tb/test_pitch_seq_2v.sv
module test_pitch_seq_2v;
   localparam int AW  = 3;
   localparam int DIV = 3;
   localparam int DEB = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_lvl = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [27:0]   mem_data;
   logic [5:0]    oct_sel, hi_sel, lo_sel;
   logic          busy;
   logic [27:0]   rom [DEPTH];

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   pitch_seq_2v #(.ADDR_W(AW), .TICK_DIV(DIV), .DEB_LEN(DEB)) i_pitch_seq_2v (
      .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .mem_addr(mem_addr),
      .mem_data(mem_data), .oct_sel(oct_sel), .hi_sel(hi_sel), .lo_sel(lo_sel),
      .busy(busy));

   always @(posedge clk) mem_data <= rom[mem_addr];

   function automatic logic [27:0] mk(input int p1, input int p0, input int d);
      return {6'(p1), 6'(p0), 16'(d)};
   endfunction

   function automatic logic [5:0] pk(input int f1, input int f0);
      return {3'(f1), 3'(f0)};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model
   int m_busy, m_armed, m_run, m_idx, m_wait, m_left, m_p0, m_p1;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_armed = 0; m_run = 0; m_idx = 0;
         m_wait = 0; m_left = 0; m_p0 = 0; m_p1 = 0;
      end else if (m_busy == 0) begin
         if (m_armed == 0) begin
            if (sync_lvl) begin
               m_run++;
               if (m_run >= DEB) m_armed = 1;
            end else m_run = 0;
         end else if (!sync_lvl) begin
            m_busy = 1; m_armed = 0; m_run = 0; m_idx = 0; m_wait = 2;
         end
      end else if (m_wait > 0) begin
         m_wait--;
         if (m_wait == 0) begin
            if (rom[m_idx][15:0] == 0) m_busy = 0;
            else begin
               m_p0 = int'(rom[m_idx][21:16]);
               m_p1 = int'(rom[m_idx][27:22]);
               m_left = int'(rom[m_idx][15:0]) * DIV;
            end
         end
      end else begin
         m_left--;
         if (m_left == 0) begin
            m_idx = (m_idx + 1) % DEPTH;
            m_wait = 2;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 busy vs model", int'(busy), m_busy);
         chk("R8 mem_addr vs model", int'(mem_addr), m_idx);
         chk("R4/R7 oct_sel vs model", int'(oct_sel), int'(pk(m_p1 / 16, m_p0 / 16)));
         chk("R4/R7 hi_sel vs model", int'(hi_sel), int'(pk((m_p1 / 4) % 4, (m_p0 / 4) % 4)));
         chk("R4/R7 lo_sel vs model", int'(lo_sel), int'(pk(m_p1 % 4, m_p0 % 4)));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog R3 actual=%0d expected=<20000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic pulse_sync(input int hi_len);
      sync_lvl = 1'b1;
      repeat (hi_len) @(negedge clk);
      sync_lvl = 1'b0;
   endtask

   initial begin
      int nbusy;
      bit wrapped, patched;
      rom[0] = mk(6'h13, 6'h2D, 2);
      rom[1] = mk(6'h00, 6'h3F, 1);
      rom[2] = mk(6'h2A, 6'h07, 3);
      rom[3] = mk(6'h15, 6'h15, 0);
      for (int i = 4; i < DEPTH; i++) rom[i] = mk(i, i + 8, 5);

      @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 selects in reset", int'({oct_sel, hi_sel, lo_sel}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mem_addr after reset", int'(mem_addr), 0);

      // R2: pulses one short of the debounce limit, split by a low cycle
      pulse_sync(DEB - 1);
      @(negedge clk);
      pulse_sync(DEB - 1);
      repeat (10) @(negedge clk);
      chk("R2 short pulses do not start", int'(busy), 0);

      // R3..R6: qualified tone starts playback
      pulse_sync(DEB + 2);
      @(negedge clk);
      chk("R3 busy after tone ends", int'(busy), 1);
      chk("R3 start address", int'(mem_addr), 0);
      nbusy = 1;
      sync_lvl = 1'b1;                  // R3: ignored while playing
      while (busy) begin
         @(negedge clk);
         if (busy) nbusy++;
         if (nbusy == 3 && busy) begin
            chk("R4 first step oct", int'(oct_sel), int'(pk(1, 2)));
            chk("R4 first step hi", int'(hi_sel), int'(pk(0, 3)));
            chk("R4 first step lo", int'(lo_sel), int'(pk(3, 1)));
            sync_lvl = 1'b0;
         end
      end
      chk("R5 busy length of 2/1/3-tick sequence", nbusy, 26);
      chk("R6 oct held after end", int'(oct_sel), int'(pk(2, 0)));
      chk("R6 hi held after end", int'(hi_sel), int'(pk(2, 1)));
      chk("R6 lo held after end", int'(lo_sel), int'(pk(2, 3)));
      chk("R8 address at end marker", int'(mem_addr), 3);
      repeat (20) @(negedge clk);
      chk("R6 stays idle without new tone", int'(busy), 0);

      // R8: address wrap
      for (int i = 0; i < DEPTH; i++) rom[i] = mk(i * 5 + 1, 63 - i * 3, 1);
      pulse_sync(DEB);
      wrapped = 0;
      patched = 0;
      @(negedge clk);
      while (busy) begin
         if (mem_addr == AW'(DEPTH - 1)) wrapped = 1;
         if (wrapped && !patched && mem_addr == 1) begin
            rom[2] = mk(0, 0, 0);
            patched = 1;
         end
         @(negedge clk);
      end
      chk("R8 address wrapped past top", int'(wrapped), 1);
      chk("R8 stop address after wrap", int'(mem_addr), 2);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule